// File: doc/BRIEF.md
# Battery Switch Drive Arbiter

This block settles, every clock, whether the charge-path switch (CHG) and the discharge-path switch (DSG) of a battery protector should be driven on. It weighs four sources against each other: autonomous protection (fault flags turn a switch off), host on/off commands that are honoured only when an options bit permits them, a manufacturing test mode in which only the host turns switches on, and body-diode protection that forces a switch on in series-switch systems. It can also drop the CHG switch while pack current is low to save power.

The active autonomous-enable state is loaded from an options bit when configuration-update mode is left and can be inverted by a toggle strobe. The block also qualifies a manual fault-recovery request against the sealed status. All inputs are synchronous; every output is registered and reflects inputs one clock later.

Top module: `fet_drive_arbiter`

## Requirements
- R1: During and after a synchronous active-low reset, `chg_en_o`, `dsg_en_o`, `auto_en_o` and `recov_ok_o` are 0 and the host request state is "none"; the usual options value at power-up is 0x18.
- R2: The options byte is decoded as bit 7 detector enable (no effect here), bit 6 host-off permit, bit 5 host-on permit, bit 4 keep-CHG-at-low-current, bit 3 series mode, bit 2 autonomous default, bit 1 reserved (no effect), bit 0 recovery permit. A `cfg_exit_i` pulse loads bit 2 into the autonomous state, and wins over a toggle in the same cycle.
- R3: A `auto_tgl_i` pulse without `cfg_exit_i` inverts the autonomous state.
- R4: `host_off_i` latches the host state OFF only when bit 6 is 1, and is otherwise ignored; if both host strobes arrive together with bit 6 set, OFF wins.
- R5: `host_on_i` latches the host state ON only when bit 5 is 1 (and no permitted host-off is present), and is otherwise ignored.
- R6: In test mode (autonomous state 0) a switch is on only when the host state is ON; fault flags have no effect.
- R7: In autonomous mode a switch is on unless its own fault flag is set or the host state is OFF; a fault keeps the switch off even after a permitted host-on.
- R8: With bit 3 set, body-diode current through a switch forces that switch on in any mode, above faults, host state and low-current drop; with bit 3 clear, body-diode inputs are ignored.
- R9: With bit 4 clear and `low_cur_i` high, CHG is off (unless R8 applies); DSG is unaffected; with bit 4 set, low current has no effect.
- R10: `recov_ok_o` is 1 for a cycle after `recov_req_i` when unsealed, or when sealed with bit 0 set; a sealed request with bit 0 clear is refused.
- R11: Each output reflects the inputs of the previous clock edge exactly one cycle later; the recovery grant lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opt_i | input | 8 | Options byte (see R2) |
| flt_chg_i | input | 1 | Protection fault requiring CHG off |
| flt_dsg_i | input | 1 | Protection fault requiring DSG off |
| host_off_i | input | 1 | Host switch-off command strobe |
| host_on_i | input | 1 | Host switch-on command strobe |
| cfg_exit_i | input | 1 | Configuration-update exit pulse |
| auto_tgl_i | input | 1 | Toggle autonomous state strobe |
| sealed_i | input | 1 | Security sealed status |
| low_cur_i | input | 1 | Pack current below low threshold |
| bd_chg_i | input | 1 | Current above threshold in CHG body diode |
| bd_dsg_i | input | 1 | Current above threshold in DSG body diode |
| recov_req_i | input | 1 | Manual fault-recovery request strobe |
| chg_en_o | output | 1 | CHG switch drive enable |
| dsg_en_o | output | 1 | DSG switch drive enable |
| auto_en_o | output | 1 | Active autonomous-control state |
| recov_ok_o | output | 1 | Recovery request accepted (one-cycle pulse) |

## Verification
The hidden state is the autonomous flag and the latched host request; a wrong value in either surfaces on the switch enables on the very next clock, because every decision feeds the registered outputs with no further delay. A mis-latched host state shows up as a switch that stays on after a permitted off or comes on in test mode, while a wrong autonomous flag is visible directly on `auto_en_o` and as faults that suddenly do or do not open a switch. Priority errors are provoked by stacking inputs in one cycle: both host strobes, configuration exit with toggle, and body-diode current against a fault or low current.

// File: rtl/fet_arb_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the switch drive arbiter.
// Assumes the options byte keeps the bit order its neighbours decode.
package fet_arb_pkg;
    localparam int OPT_W     = 8;
    localparam int NUM_SW    = 2;
    localparam int SW_CHG    = 0;
    localparam int SW_DSG    = 1;
    localparam logic [OPT_W-1:0] OPT_POR = 8'h18;

    // Options byte, MSB first.
    typedef struct packed {
        logic det_en;
        logic host_off_ok;
        logic host_on_ok;
        logic chg_keep_low;
        logic series;
        logic auto_dflt;
        logic rsvd;
        logic recov_ok;
    } fet_opts_t;

    // Latched host request.
    typedef enum logic [1:0] {
        HOST_NONE = 2'd0,
        HOST_OFF  = 2'd1,
        HOST_ON   = 2'd2
    } host_req_e;
endpackage

// File: rtl/fet_auto_state.sv
`timescale 1ns/1ps
// Module: holds the active autonomous-control flag.
// Loads the default on configuration exit (wins over toggle), inverts on toggle.
// Assumes strobes are one-cycle synchronous pulses.
module fet_auto_state (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_exit_i,
    input  logic toggle_i,
    input  logic dflt_i,
    output logic auto_nxt_o,
    output logic auto_q_o
);
    // Next-state selection: load beats toggle beats hold.
    always_comb begin
        if (cfg_exit_i)    auto_nxt_o = dflt_i;
        else if (toggle_i) auto_nxt_o = ~auto_q_o;
        else               auto_nxt_o = auto_q_o;
    end

    // State register, cleared to test mode on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) auto_q_o <= 1'b0;
        else        auto_q_o <= auto_nxt_o;
    end

    p_load_default_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_exit_i |=> (auto_q_o == $past(dflt_i)));
    p_toggle_invert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_i && !cfg_exit_i) |=> (auto_q_o != $past(auto_q_o)));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle_i && !cfg_exit_i) |=> $stable(auto_q_o));
endmodule

// File: rtl/fet_host_latch.sv
`timescale 1ns/1ps
// Module: latches the last permitted host switch command.
// Off beats on in the same cycle; commands without permission leave the state.
module fet_host_latch
    import fet_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      off_req_i,
    input  logic      on_req_i,
    input  logic      off_ok_i,
    input  logic      on_ok_i,
    output host_req_e host_nxt_o,
    output host_req_e host_q_o
);
    logic off_take;
    logic on_take;

    // Qualify each strobe by its permit bit.
    always_comb begin
        off_take = off_req_i && off_ok_i;
        on_take  = on_req_i && on_ok_i;
    end

    // Next request: permitted off, else permitted on, else hold.
    always_comb begin
        if (off_take)     host_nxt_o = HOST_OFF;
        else if (on_take) host_nxt_o = HOST_ON;
        else              host_nxt_o = host_q_o;
    end

    // Request register, no request after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) host_q_o <= HOST_NONE;
        else        host_q_o <= host_nxt_o;
    end

    p_off_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (off_req_i && off_ok_i) |=> (host_q_o == HOST_OFF));
    p_off_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (off_req_i && !off_ok_i && !(on_req_i && on_ok_i)) |=> $stable(host_q_o));
    p_on_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (on_req_i && !on_ok_i && !(off_req_i && off_ok_i)) |=> $stable(host_q_o));
endmodule

// File: rtl/fet_switch_decide.sv
`timescale 1ns/1ps
// Module: decides and registers one switch enable.
// Priority: body-diode forcing, then low-current drop (CHG variant only),
// then the mode rule (autonomous: fault and host-off open it; test: host-on closes it).
module fet_switch_decide
    import fet_arb_pkg::*;
#(
    parameter bit LOW_CUR_DROP = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      auto_nxt_i,
    input  host_req_e host_nxt_i,
    input  logic      fault_i,
    input  logic      bd_cur_i,
    input  logic      series_i,
    input  logic      low_cur_i,
    input  logic      keep_low_i,
    output logic      en_q_o
);
    logic bd_force;
    logic low_drop;
    logic mode_on;
    logic en_d;

    // Combine the sources into the next enable.
    always_comb begin
        bd_force = series_i && bd_cur_i;
        low_drop = LOW_CUR_DROP && low_cur_i && !keep_low_i;
        if (auto_nxt_i) mode_on = !fault_i && (host_nxt_i != HOST_OFF);
        else            mode_on = (host_nxt_i == HOST_ON);
        en_d = bd_force || (!low_drop && mode_on);
    end

    // Output register, switch off on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q_o <= 1'b0;
        else        en_q_o <= en_d;
    end

    p_bd_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (series_i && bd_cur_i) |=> en_q_o);
    p_test_mode_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_nxt_i && (host_nxt_i != HOST_ON) && !(series_i && bd_cur_i)) |=> !en_q_o);
    p_fault_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_nxt_i && fault_i && !(series_i && bd_cur_i)) |=> !en_q_o);

    if (LOW_CUR_DROP) begin : g_low_chk
        p_low_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (low_cur_i && !keep_low_i && !(series_i && bd_cur_i)) |=> !en_q_o);
    end
endmodule

// File: rtl/fet_recov_gate.sv
`timescale 1ns/1ps
// Module: qualifies a manual recovery request against sealed status.
// Emits a registered one-cycle grant per request cycle.
module fet_recov_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic sealed_i,
    input  logic permit_i,
    output logic ok_q_o
);
    // Grant register: unsealed, or sealed with permission.
    always_ff @(posedge clk) begin
        if (!rst_n) ok_q_o <= 1'b0;
        else        ok_q_o <= req_i && (!sealed_i || permit_i);
    end

    p_sealed_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sealed_i && !permit_i) |=> !ok_q_o);
    p_unsealed_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !sealed_i) |=> ok_q_o);
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !ok_q_o);
endmodule

// File: rtl/fet_drive_arbiter.sv
`timescale 1ns/1ps
// Module: top of the battery switch drive arbiter.
// Decodes the options byte, keeps autonomous and host state, and registers
// the CHG/DSG enables and the recovery grant. All inputs are synchronous.
module fet_drive_arbiter
    import fet_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPT_W-1:0] opt_i,
    input  logic             flt_chg_i,
    input  logic             flt_dsg_i,
    input  logic             host_off_i,
    input  logic             host_on_i,
    input  logic             cfg_exit_i,
    input  logic             auto_tgl_i,
    input  logic             sealed_i,
    input  logic             low_cur_i,
    input  logic             bd_chg_i,
    input  logic             bd_dsg_i,
    input  logic             recov_req_i,
    output logic             chg_en_o,
    output logic             dsg_en_o,
    output logic             auto_en_o,
    output logic             recov_ok_o
);
    fet_opts_t         opts;
    logic              auto_nxt;
    host_req_e         host_nxt;
    host_req_e         host_q;
    logic [NUM_SW-1:0] flt_v;
    logic [NUM_SW-1:0] bd_v;
    logic [NUM_SW-1:0] en_v;
    logic              unused_opt_bits;
    host_req_e         unused_host_q;

    // Decode the options byte and gather per-switch inputs.
    always_comb begin
        opts              = fet_opts_t'(opt_i);
        flt_v[SW_CHG]     = flt_chg_i;
        flt_v[SW_DSG]     = flt_dsg_i;
        bd_v[SW_CHG]      = bd_chg_i;
        bd_v[SW_DSG]      = bd_dsg_i;
        unused_opt_bits   = opts.det_en ^ opts.rsvd;
        unused_host_q     = host_q;
    end

    fet_auto_state u_auto (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_exit_i (cfg_exit_i),
        .toggle_i   (auto_tgl_i),
        .dflt_i     (opts.auto_dflt),
        .auto_nxt_o (auto_nxt),
        .auto_q_o   (auto_en_o)
    );

    fet_host_latch u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .off_req_i  (host_off_i),
        .on_req_i   (host_on_i),
        .off_ok_i   (opts.host_off_ok),
        .on_ok_i    (opts.host_on_ok),
        .host_nxt_o (host_nxt),
        .host_q_o   (host_q)
    );

    for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
        fet_switch_decide #(
            .LOW_CUR_DROP (g == SW_CHG)
        ) u_sw (
            .clk        (clk),
            .rst_n      (rst_n),
            .auto_nxt_i (auto_nxt),
            .host_nxt_i (host_nxt),
            .fault_i    (flt_v[g]),
            .bd_cur_i   (bd_v[g]),
            .series_i   (opts.series),
            .low_cur_i  (low_cur_i),
            .keep_low_i (opts.chg_keep_low),
            .en_q_o     (en_v[g])
        );
    end

    fet_recov_gate u_recov (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (recov_req_i),
        .sealed_i (sealed_i),
        .permit_i (opts.recov_ok),
        .ok_q_o   (recov_ok_o)
    );

    // Drive the switch enables from the per-switch registers.
    always_comb begin
        chg_en_o = en_v[SW_CHG];
        dsg_en_o = en_v[SW_DSG];
    end

    p_dsg_low_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (low_cur_i && !flt_dsg_i && auto_nxt && (host_nxt != HOST_OFF)) |=> dsg_en_o);
endmodule

// File: tb/fet_drive_arbiter_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard. The driver applies one stimulus per cycle at the falling
// edge and queues the expected outputs; the monitor compares after the next
// rising edge.
module fet_drive_arbiter_bench;
    import fet_arb_pkg::*;

    typedef struct {
        logic  chg;
        logic  dsg;
        logic  auto_en;
        logic  rec;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opt = OPT_POR;
    logic flt_chg = 0, flt_dsg = 0, h_off = 0, h_on = 0, cfg = 0, tgl = 0;
    logic sealed = 0, low = 0, bd_chg = 0, bd_dsg = 0, rec = 0;
    logic chg_en, dsg_en, auto_en, rec_ok;

    // stimulus staged by the test, applied by the driver
    logic [7:0] s_opt = OPT_POR;
    logic s_flt_chg = 0, s_flt_dsg = 0, s_off = 0, s_on = 0, s_cfg = 0, s_tgl = 0;
    logic s_sealed = 0, s_low = 0, s_bd_chg = 0, s_bd_dsg = 0, s_rec = 0;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    fet_drive_arbiter u_fet_drive_arbiter (
        .clk (clk), .rst_n (rst_n), .opt_i (opt),
        .flt_chg_i (flt_chg), .flt_dsg_i (flt_dsg),
        .host_off_i (h_off), .host_on_i (h_on),
        .cfg_exit_i (cfg), .auto_tgl_i (tgl), .sealed_i (sealed),
        .low_cur_i (low), .bd_chg_i (bd_chg), .bd_dsg_i (bd_dsg),
        .recov_req_i (rec),
        .chg_en_o (chg_en), .dsg_en_o (dsg_en),
        .auto_en_o (auto_en), .recov_ok_o (rec_ok)
    );

    task automatic go(input logic e_chg, input logic e_dsg, input logic e_auto,
                      input logic e_rec, input string tag);
        exp_t e;
        @(negedge clk);
        opt = s_opt; flt_chg = s_flt_chg; flt_dsg = s_flt_dsg;
        h_off = s_off; h_on = s_on; cfg = s_cfg; tgl = s_tgl;
        sealed = s_sealed; low = s_low; bd_chg = s_bd_chg; bd_dsg = s_bd_dsg;
        rec = s_rec;
        e.chg = e_chg; e.dsg = e_dsg; e.auto_en = e_auto; e.rec = e_rec; e.tag = tag;
        q.push_back(e);
        s_off = 0; s_on = 0; s_cfg = 0; s_tgl = 0; s_rec = 0;
    endtask

    // Monitor: compare one queued item per rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if ({chg_en, dsg_en, auto_en, rec_ok} !== {e.chg, e.dsg, e.auto_en, e.rec}) begin
                    errors++;
                    $display("FAIL %s: chg/dsg/auto/rec = %b%b%b%b expected %b%b%b%b",
                             e.tag, chg_en, dsg_en, auto_en, rec_ok,
                             e.chg, e.dsg, e.auto_en, e.rec);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({chg_en, dsg_en, auto_en, rec_ok} !== 4'b0000) begin
            errors++;
            $display("FAIL R1: reset outputs %b%b%b%b expected 0000",
                     chg_en, dsg_en, auto_en, rec_ok);
        end
        rst_n = 1'b1;

        go(0,0,0,0, "R1 idle after reset");
        s_on = 1;                             go(0,0,0,0, "R5 host-on without permit");
        s_cfg = 1;                            go(0,0,0,0, "R2 load default 0");
        s_tgl = 1;                            go(1,1,1,0, "R3 toggle to autonomous");
        s_flt_chg = 1;                        go(0,1,1,0, "R7 CHG fault opens CHG");
        s_opt = 8'h78; s_on = 1;              go(0,1,1,0, "R7 fault beats host-on");
        s_flt_chg = 0;                        go(1,1,1,0, "R7 fault cleared");
        s_off = 1; s_on = 1;                  go(0,0,1,0, "R4 off wins over on");
        s_opt = 8'h18; s_on = 1;              go(0,0,1,0, "R5 host-on ignored");
        s_opt = 8'h78; s_on = 1;              go(1,1,1,0, "R5 host-on permitted");
        s_opt = 8'h18; s_off = 1;             go(1,1,1,0, "R4 host-off ignored");
        s_tgl = 1;                            go(1,1,0,0, "R6 test mode host on");
        s_opt = 8'h78; s_off = 1;             go(0,0,0,0, "R6 test mode host off");
        s_on = 1; s_flt_chg = 1; s_flt_dsg = 1; go(1,1,0,0, "R6 faults ignored in test");
        s_flt_chg = 0; s_flt_dsg = 0;         go(1,1,0,0, "R6 hold");
        s_off = 1;                            go(0,0,0,0, "R6 off again");
        s_bd_dsg = 1;                         go(0,1,0,0, "R8 series body diode DSG");
        s_opt = 8'h70;                        go(0,0,0,0, "R8 parallel ignores body diode");
        s_bd_dsg = 0; s_opt = 8'h64; s_cfg = 1; go(0,0,1,0, "R2 load default 1");
        s_on = 1;                             go(1,1,1,0, "R5 host on");
        s_low = 1;                            go(0,1,1,0, "R9 low current drops CHG");
        s_opt = 8'h74;                        go(1,1,1,0, "R9 keep CHG at low current");
        s_opt = 8'h6C; s_bd_chg = 1;          go(1,1,1,0, "R8 body diode beats low drop");
        s_bd_chg = 0;                         go(0,1,1,0, "R9 low drop again");
        s_low = 0; s_cfg = 1; s_tgl = 1;      go(1,1,1,0, "R2 cfg exit beats toggle");
        s_flt_chg = 1; s_bd_chg = 1;          go(1,1,1,0, "R8 body diode beats fault");
        s_bd_chg = 0;                         go(0,1,1,0, "R7 fault opens CHG");
        s_flt_chg = 0; s_rec = 1;             go(1,1,1,1, "R10 unsealed recovery");
                                              go(1,1,1,0, "R11 grant is one cycle");
        s_sealed = 1; s_rec = 1;              go(1,1,1,0, "R10 sealed refused");
        s_opt = 8'h6D; s_rec = 1;             go(1,1,1,1, "R10 sealed permitted");
        s_tgl = 1;                            go(1,1,0,0, "R11 toggle seen next cycle");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule